// File: doc/BRIEF.md
# Watchdog Timer with Two-Word Unlock Sequences

This block is a memory-mapped watchdog timer. It counts upward in a slow time base, marked by a one-cycle `tick` strobe that arrives at about 32 kHz inside the fast bus clock domain. When the count passes the all-ones value while the watchdog is armed, the block raises `rst_out` for one clock and the count restarts from the programmed load value. Software keeps the system alive by writing a new value to the trigger register, and each such write restarts the count from the load value.

Software cannot start or stop the watchdog with a single write. Arming takes two words written in order to the arm register, and disarming takes a different pair of words. An optional prescaler slows the count by a power of two. A write to a control, load, trigger or arm register is posted. The register shows a busy flag in the pending register for a fixed number of ticks after the write. Further writes to a register are dropped while its flag is set.

Top module: `wdog_unlock_timer`

## Requirements
- R1: After reset the count, load, control, last-trigger and pending registers read 0, the watchdog is disarmed, `rst_out` is 0, and ticks do not move the count.
- R2: Writing 0x0000BBBB and then 0x00004444 to the arm register (address 6) arms the watchdog, and each later tick advances the count.
- R3: Writing 0x0000AAAA and then 0x00005555 to the arm register disarms the watchdog, and the count then holds its value across ticks.
- R4: When a first word of a sequence is followed by any other word, the sequence returns to idle and the armed state does not change. A second word written on its own does nothing.
- R5: A write to the trigger register (address 4) whose value differs from the last value taken by that register loads the count from the load register (address 3) in the same clock. A write of the same value leaves the count untouched.
- R6: With control bit 5 clear, the armed count advances by one on every tick. With bit 5 set, it advances once every 2^P ticks counted from the last reload, where P is control bits 4:2 (address 1).
- R7: When an armed count advances past 0xFFFFFFFF, `rst_out` is 1 for exactly one clock and the count is loaded from the load register.
- R8: The pending register (address 5) shows busy bits for the posted registers: bit 0 control, bit 2 load, bit 3 trigger, bit 4 arm. A bit is set in the clock after an accepted write and clears on the BUSY_TICKS-th tick that follows.
- R9: A write to a register whose busy bit is set is ignored, and the register keeps its earlier value.
- R10: Address 0 reads the fixed revision code REV_CODE in bits 7:0 and zero above. Reads return data in the clock after `rd_en`, and the count register (address 2) is read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the slow time base |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the clock after `rd_en` |
| rst_out | output | 1 | One-clock system reset pulse on overflow |

## Verification
The assertions check four things on every clock:
- the overflow pulse lasts only one cycle and leaves the count at the earlier load value;
- the count changes only on a tick or a trigger reload, and stays frozen while the watchdog is disarmed;
- an accepted control write raises its busy bit;
- a load write made while its register is busy leaves the load value unchanged.

Only the bench scenarios can show the rest, because each depends on a history of several bus writes: the ordering rules of the two-word sequences, the rejection of a repeated trigger value, the exact prescaled step interval and the reload after a wrap through all ones.

// File: rtl/wdu_pkg.sv
// Package: shared address map, sequence words and pending-bit positions
// for the two-word unlock watchdog. Assumes a 3-bit word address.
package wdu_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_REV   = 3'd0,
        A_CTRL  = 3'd1,
        A_COUNT = 3'd2,
        A_LOAD  = 3'd3,
        A_TRIG  = 3'd4,
        A_PEND  = 3'd5,
        A_ARM   = 3'd6
    } reg_addr_e;

    localparam logic [15:0] ARM_WORD1    = 16'hBBBB;
    localparam logic [15:0] ARM_WORD2    = 16'h4444;
    localparam logic [15:0] DISARM_WORD1 = 16'hAAAA;
    localparam logic [15:0] DISARM_WORD2 = 16'h5555;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ARMING = 2'd1,
        SQ_DISARM = 2'd2
    } seq_e;

    // Pending register bit positions (software decodes these)
    localparam int PB_CTRL = 0;
    localparam int PB_LOAD = 2;
    localparam int PB_TRIG = 3;
    localparam int PB_ARM  = 4;
    localparam int PEND_W  = 5;

endpackage

// File: rtl/wdu_busy.sv
// Module: posted-write busy tracker for one register.
// Raises busy when an accepted write starts it and holds it for BUSY_TICKS
// slow ticks. Assumes start never arrives while busy (caller gates it).
module wdu_busy #(
    parameter int BUSY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_TICKS + 1);

    logic [CW-1:0] left_q;

    // Load the tick budget on start, count it down on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CW'(BUSY_TICKS);
        end else if (tick && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/wdu_unlock.sv
// Module: two-word arm/disarm sequence tracker.
// Each accepted write to the arm register steps the state. A wrong second
// word returns to idle and leaves the armed state as it was.
module wdu_unlock #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] word,
    output logic              armed
);
    import wdu_pkg::*;

    seq_e st_q;

    // Step the sequence state and update the armed flag on a matching pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            armed <= 1'b0;
        end else if (wr) begin
            case (st_q)
                SQ_IDLE: begin
                    if (word == DATA_W'(ARM_WORD1))         st_q <= SQ_ARMING;
                    else if (word == DATA_W'(DISARM_WORD1)) st_q <= SQ_DISARM;
                end
                SQ_ARMING: begin
                    if (word == DATA_W'(ARM_WORD2)) armed <= 1'b1;
                    st_q <= SQ_IDLE;
                end
                SQ_DISARM: begin
                    if (word == DATA_W'(DISARM_WORD2)) armed <= 1'b0;
                    st_q <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdu_counter.sv
// Module: prescaled up-counter with overflow pulse.
// Advances on tick while armed, once every 2^ptv ticks when the prescaler
// is on. A reload request wins over counting and clears the prescaler.
module wdu_counter #(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             armed,
    input  logic             pre_on,
    input  logic [PTV_W-1:0] ptv,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int PRE_W = (1 << PTV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic             step;

    // Prescaler limit: 2^ptv - 1 ticks between steps
    always_comb begin
        pre_lim = PRE_W'((1 << ptv) - 1);
        step    = !pre_on || (pre_q == pre_lim);
    end

    // Count, prescale and flag the wrap through all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pre_q <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (reload) begin
                count <= load_val;
                pre_q <= '0;
            end else if (tick && armed) begin
                if (step) begin
                    pre_q <= '0;
                    if (count == {CNT_W{1'b1}}) begin
                        count <= load_val;
                        ovf   <= 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_unlock_timer.sv
// Module: watchdog timer top level with register decode and read mux.
// Assumes tick is a one-cycle strobe in the clk domain. Posted writes take
// effect at once. Busy flags only pace software and drop writes.
module wdog_unlock_timer #(
    parameter int         DATA_W     = 32,
    parameter int         PTV_W      = 3,
    parameter int         BUSY_TICKS = 2,
    parameter logic [7:0] REV_CODE   = 8'h5A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [wdu_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rst_out
);
    import wdu_pkg::*;

    localparam int CTRL_W = PTV_W + 3;
    localparam int NBUSY  = 4;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]  load_q;
    logic [DATA_W-1:0]  trig_last;
    logic [DATA_W-1:0]  count_q;
    logic               en_q;
    logic               trig_hit;
    logic [NBUSY-1:0]   busy;
    logic [NBUSY-1:0]   acc;
    logic [PEND_W-1:0]  pend_vec;
    reg_addr_e          sel;

    assign sel = reg_addr_e'(addr);

    // Accept a write only when its register is not busy
    always_comb begin
        acc[0] = wr_en && sel == A_CTRL && !busy[0];
        acc[1] = wr_en && sel == A_LOAD && !busy[1];
        acc[2] = wr_en && sel == A_TRIG && !busy[2];
        acc[3] = wr_en && sel == A_ARM  && !busy[3];
        trig_hit = acc[2] && (wdata != trig_last);
    end

    // One busy tracker per posted register
    for (genvar g = 0; g < NBUSY; g++) begin : g_busy
        wdu_busy #(.BUSY_TICKS(BUSY_TICKS)) busy_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .start (acc[g]),
            .busy  (busy[g])
        );
    end

    // Place busy flags at their pending-register bit positions
    always_comb begin
        pend_vec          = '0;
        pend_vec[PB_CTRL] = busy[0];
        pend_vec[PB_LOAD] = busy[1];
        pend_vec[PB_TRIG] = busy[2];
        pend_vec[PB_ARM]  = busy[3];
    end

    // Capture control, load and last trigger values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            load_q    <= '0;
            trig_last <= '0;
        end else begin
            if (acc[0]) ctrl_q    <= wdata[CTRL_W-1:0];
            if (acc[1]) load_q    <= wdata;
            if (acc[2]) trig_last <= wdata;
        end
    end

    wdu_unlock #(.DATA_W(DATA_W)) unlock_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (acc[3]),
        .word  (wdata),
        .armed (en_q)
    );

    wdu_counter #(.CNT_W(DATA_W), .PTV_W(PTV_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .armed    (en_q),
        .pre_on   (ctrl_q[PTV_W+2]),
        .ptv      (ctrl_q[PTV_W+1:2]),
        .reload   (trig_hit),
        .load_val (load_q),
        .count    (count_q),
        .ovf      (rst_out)
    );

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                A_REV:   rdata <= DATA_W'(REV_CODE);
                A_CTRL:  rdata <= DATA_W'(ctrl_q);
                A_COUNT: rdata <= count_q;
                A_LOAD:  rdata <= load_q;
                A_TRIG:  rdata <= trig_last;
                A_PEND:  rdata <= DATA_W'(pend_vec);
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wdu_checker.sv
// Module: assertion checker bound to the watchdog top level.
// Observes ports and internal state. It drives nothing.
module wdu_checker #(
    parameter int DATA_W = 32,
    parameter int PEND_W = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic                       wr_en,
    input logic [wdu_pkg::ADDR_W-1:0] addr,
    input logic                       rst_out,
    input logic [DATA_W-1:0]          count_q,
    input logic [DATA_W-1:0]          load_q,
    input logic                       en_q,
    input logic                       trig_hit,
    input logic [PEND_W-1:0]          pend_vec
);
    import wdu_pkg::*;

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !rst_out); // R7

    AST_RST_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> count_q == $past(load_q)); // R7

    AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !trig_hit) |=> $stable(count_q)); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !trig_hit) |=> $stable(count_q)); // R6

    AST_CTRL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && !pend_vec[PB_CTRL]) |=> pend_vec[PB_CTRL]); // R8

    AST_BUSY_LOAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LOAD && pend_vec[PB_LOAD]) |=> $stable(load_q)); // R9
endmodule

bind wdog_unlock_timer wdu_checker #(.DATA_W(DATA_W), .PEND_W(wdu_pkg::PEND_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .rst_out  (rst_out),
    .count_q  (count_q),
    .load_q   (load_q),
    .en_q     (en_q),
    .trig_hit (trig_hit),
    .pend_vec (pend_vec)
);

// File: tb/wdog_unlock_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected read values. Read tasks queue expectations
// and a monitor compares each returned read word in order.
module wdog_unlock_timer_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rst_out;
    logic          rd_pend = 1'b0;
    logic          done = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    wdog_unlock_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_out(rst_out)
    );

    // Monitor: pop and compare each read result
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", t, act, e);
        end
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and R10 revision
        chk_bit(rst_out, 1'b0, "R1 rst_out after reset");
        rd_exp(3'd0, 32'h0000005A, "R10 revision");
        rd_exp(3'd2, 32'h0, "R1 count after reset");
        rd_exp(3'd5, 32'h0, "R1 pending after reset");
        tk(3);
        rd_exp(3'd2, 32'h0, "R1 disarmed count holds");
        // R8 load pending and R9 busy drop
        wr(3'd3, 32'd100);
        rd_exp(3'd5, 32'h4, "R8 load busy bit 2");
        wr(3'd3, 32'd200);
        tk(2);
        rd_exp(3'd5, 32'h0, "R8 pending clears");
        rd_exp(3'd3, 32'd100, "R9 busy load write dropped");
        wr(3'd2, 32'd5);
        rd_exp(3'd2, 32'h0, "R10 count read-only");
        // R5 trigger reload
        wr(3'd4, 32'd1);
        rd_exp(3'd2, 32'd100, "R5 trigger reloads");
        tk(2);
        // R2 arm sequence
        wr(3'd6, 32'h0000BBBB);
        tk(2);
        wr(3'd6, 32'h00004444);
        tk(2);
        rd_exp(3'd2, 32'd102, "R2 armed count advances");
        tk(3);
        rd_exp(3'd2, 32'd105, "R6 one step per tick");
        // R5 repeated value ignored, new value reloads
        wr(3'd4, 32'd1);
        tk(2);
        rd_exp(3'd2, 32'd107, "R5 same trigger value no reload");
        wr(3'd4, 32'd2);
        rd_exp(3'd2, 32'd100, "R5 new trigger value reloads");
        rd_exp(3'd5, 32'h8, "R8 trigger busy bit 3");
        tk(2);
        // R4 broken sequences
        wr(3'd6, 32'h0000AAAA);
        tk(2);
        wr(3'd6, 32'h00001234);
        tk(2);
        rd_exp(3'd2, 32'd106, "R4 wrong second word keeps armed");
        wr(3'd6, 32'h00005555);
        tk(2);
        rd_exp(3'd2, 32'd108, "R4 lone second word ignored");
        // R3 disarm
        wr(3'd6, 32'h0000AAAA);
        tk(2);
        wr(3'd6, 32'h00005555);
        tk(2);
        rd_exp(3'd2, 32'd110, "R3 disarmed count holds");
        // R6 prescaler: bit 5 on, exponent 2
        wr(3'd1, 32'h28);
        rd_exp(3'd5, 32'h1, "R8 control busy bit 0");
        tk(2);
        rd_exp(3'd1, 32'h28, "R6 control readback");
        wr(3'd6, 32'h0000BBBB);
        tk(2);
        wr(3'd6, 32'h00004444);
        wr(3'd4, 32'd3);
        tk(3);
        rd_exp(3'd2, 32'd100, "R6 prescaled no step after 3 ticks");
        tk(1);
        rd_exp(3'd2, 32'd101, "R6 prescaled step on 4th tick");
        // R7 overflow
        wr(3'd1, 32'h0);
        tk(2);
        wr(3'd3, 32'hFFFFFFF0);
        tk(2);
        wr(3'd4, 32'd4);
        tk(15);
        rd_exp(3'd2, 32'hFFFFFFFF, "R7 count at all ones");
        chk_bit(rst_out, 1'b0, "R7 no pulse before wrap");
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk_bit(rst_out, 1'b1, "R7 pulse on wrap");
        @(negedge clk);
        chk_bit(rst_out, 1'b0, "R7 pulse is one cycle");
        rd_exp(3'd2, 32'hFFFFFFF0, "R7 count reloaded after wrap");
        // R9 busy control write dropped
        wr(3'd1, 32'h3C);
        wr(3'd1, 32'h20);
        rd_exp(3'd1, 32'h3C, "R9 busy control write dropped");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule